// File: doc/BRIEF.md
# Configuration Frame Write Engine

The engine takes configuration data as 128-bit beats of four 32-bit words each. It packs consecutive beats into a frame buffer. Once a whole frame is held, the engine writes that frame into a frame memory, at the location given by the current frame address, and then advances the address. A frame address has two parts: a frame index, and a block-type number above it. When the index steps past the last frame configured for its block type, the index restarts at zero and the block type moves on to the next one.

Each block type has a last-frame limit, and these limits arrive as static inputs. The block counts as configured only while at least one limit is nonzero. Until then it ignores commands, address loads and data. A five-bit command input sets and clears three mode flags: write mode, read mode, and row power.

Top module: `cfg_frame_writer`

## Requirements
- R1: Reset leaves the flags, the frame address, the overflow flag and the commit pulse at zero, and every frame memory location reads zero.
- R2: `row_cfgd` is high exactly when some limit is nonzero. While it is low, commands and address loads change nothing.
- R3: Command 1 sets write mode, 2 powers the row on, 3 powers it off, 4 sets read mode and 5 clears both write and read mode. Any other code leaves all flags unchanged.
- R4: A beat is taken only while the row is on and write mode is set. Read mode alone admits nothing.
- R5: Word 0 of a frame is beat bits 31:0 of the first beat. Beat k fills frame words 4k to 4k+3. On the clock edge after the buffer fills, the frame is written at memory index `far_q[MEM_AW-1:0]` and the buffer empties.
- R6: A commit adds one to the index in bits 19:0. If the result exceeds the limit of the block type in bits 22:20, the index becomes 0 and the block type adds one.
- R7: At block type 6 a wrap clears the index and leaves the block type at 6.
- R8: An address load stores bits 24:0. Bits 31:25 of `far_q` always read zero.
- R9: A beat that arrives in the commit cycle is dropped and sets `overflow`, which stays set until reset.
- R10: `commit` pulses for one cycle per frame, and `commit_addr` carries the 23-bit address that was used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| last_frame | input | BT_COUNT*IDX_W | Last-frame limit per block type, type 0 in the low bits |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 5 | Command code |
| far_wr | input | 1 | Frame address load strobe |
| far_wdata | input | 32 | Frame address load value |
| beat_valid | input | 1 | Data beat strobe |
| beat_data | input | 128 | Data beat, word 0 in bits 31:0 |
| rd_addr | input | MEM_AW | Frame memory read index |
| rd_frame | output | FRAME_WORDS*32 | Frame stored at `rd_addr` |
| far_q | output | 32 | Current frame address |
| row_cfgd | output | 1 | Some limit is nonzero |
| row_on | output | 1 | Row power flag |
| wcfg | output | 1 | Write mode flag |
| rcfg | output | 1 | Read mode flag |
| overflow | output | 1 | Sticky dropped-beat flag |
| commit | output | 1 | Frame written this cycle |
| commit_addr | output | IDX_W+BT_W | Address of the last committed frame |

## Verification
The bench builds the engine with eight-word frames, which is two beats per frame, and a 16-entry memory. At that size the commit cycle, the window in which a beat is dropped, and aliasing of memory indices all show up within a few beats. Limits of 2, 0 and 1 carry the address through an ordinary step, a wrap into the next block type, a block type whose limit is zero, and the saturation at block type 6. Reaching block type 6 takes one address load, not thousands of frames.

// File: rtl/cfg_frame_writer.sv
module cfg_frame_writer #(
  parameter int FRAME_WORDS = 8,
  parameter int MEM_AW      = 4,
  parameter int IDX_W       = 20,
  parameter int BT_W        = 3,
  parameter int BT_COUNT    = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BT_COUNT*IDX_W-1:0]   last_frame,
  input  logic                        cmd_valid,
  input  logic [4:0]                  cmd_code,
  input  logic                        far_wr,
  input  logic [31:0]                 far_wdata,
  input  logic                        beat_valid,
  input  logic [127:0]                beat_data,
  input  logic [MEM_AW-1:0]           rd_addr,
  output logic [FRAME_WORDS*32-1:0]   rd_frame,
  output logic [31:0]                 far_q,
  output logic                        row_cfgd,
  output logic                        row_on,
  output logic                        wcfg,
  output logic                        rcfg,
  output logic                        overflow,
  output logic                        commit,
  output logic [IDX_W+BT_W-1:0]       commit_addr
);
  localparam int BEATS      = FRAME_WORDS / 4;
  localparam int CW         = $clog2(BEATS + 1);
  localparam int FRAME_BITS = FRAME_WORDS * 32;
  localparam int ADDR_W     = IDX_W + BT_W;
  localparam int BT_MAX     = BT_COUNT - 1;
  localparam int DEPTH      = 1 << MEM_AW;
  localparam int FAR_W      = 25;

  localparam logic [4:0] C_WRITE = 5'd1, C_ON = 5'd2, C_OFF = 5'd3,
                         C_READ  = 5'd4, C_PARK = 5'd5;

  logic [FAR_W-1:0]      far_r, far_next;
  logic [CW-1:0]         cnt;
  logic [127:0]          beat_buf [BEATS];
  logic [FRAME_BITS-1:0] frame_bits;
  logic [FRAME_BITS-1:0] mem [DEPTH];
  logic [IDX_W-1:0]      cur_limit;
  logic [IDX_W:0]        idx_inc;

  wire [IDX_W-1:0] idx      = far_r[IDX_W-1:0];
  wire [BT_W-1:0]  bt       = far_r[ADDR_W-1:IDX_W];
  wire             accept   = row_cfgd && row_on && wcfg && beat_valid;
  wire             room     = cnt < CW'(BEATS);
  wire             push     = accept && room;
  wire             full     = cnt == CW'(BEATS);
  wire             wrap     = idx_inc > {1'b0, cur_limit};
  wire             load_far = row_cfgd && far_wr;

  assign row_cfgd = |last_frame;
  assign far_q    = {{(32-FAR_W){1'b0}}, far_r};
  assign rd_frame = mem[rd_addr];
  assign idx_inc  = {1'b0, idx} + {{IDX_W{1'b0}}, 1'b1};

  for (genvar k = 0; k < BEATS; k++) begin : g_pack
    assign frame_bits[k*128 +: 128] = beat_buf[k];
  end

  always_comb begin
    cur_limit = '0;
    for (int b = 0; b < BT_COUNT; b++)
      if (bt == BT_W'(b)) cur_limit = last_frame[b*IDX_W +: IDX_W];
  end

  always_comb begin
    far_next = far_r;
    if (wrap) begin
      far_next[IDX_W-1:0] = '0;
      if (bt < BT_W'(BT_MAX)) far_next[ADDR_W-1:IDX_W] = bt + 1'b1;
    end else begin
      far_next[IDX_W-1:0] = idx_inc[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_on <= 1'b0;
      wcfg   <= 1'b0;
      rcfg   <= 1'b0;
    end else if (row_cfgd && cmd_valid) begin
      case (cmd_code)
        C_WRITE: wcfg <= 1'b1;
        C_ON:    row_on <= 1'b1;
        C_OFF:   row_on <= 1'b0;
        C_READ:  rcfg <= 1'b1;
        C_PARK:  begin wcfg <= 1'b0; rcfg <= 1'b0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      far_r       <= '0;
      cnt         <= '0;
      overflow    <= 1'b0;
      commit      <= 1'b0;
      commit_addr <= '0;
      for (int k = 0; k < BEATS; k++) beat_buf[k] <= '0;
    end else begin
      commit <= full;
      if (accept && !room) overflow <= 1'b1;
      if (full) begin
        cnt         <= '0;
        commit_addr <= far_r[ADDR_W-1:0];
      end else if (push) begin
        cnt <= cnt + 1'b1;
      end
      for (int k = 0; k < BEATS; k++)
        if (push && cnt == CW'(k)) beat_buf[k] <= beat_data;
      if (load_far)  far_r <= far_wdata[FAR_W-1:0];
      else if (full) far_r <= far_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
    end else if (full) begin
      mem[far_r[MEM_AW-1:0]] <= frame_bits;
    end
  end

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r10_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  a_r5_buffer_empties: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (cnt == '0) && commit);

  a_r2_unconfigured_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !row_cfgd |=> $stable({row_on, wcfg, rcfg}) && $stable(far_r));

  a_r4_no_fill_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!(row_on && wcfg) && !full) |=> $stable(cnt));

  a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !load_far && idx < cur_limit) |=>
      far_r[IDX_W-1:0] == $past(far_r[IDX_W-1:0]) + 1'b1);

  a_r7_type_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !load_far && bt <= BT_W'(BT_MAX)) |=>
      far_r[ADDR_W-1:IDX_W] <= BT_W'(BT_MAX));
endmodule

// File: tb/test_cfg_frame_writer.sv
module test_cfg_frame_writer;
  localparam int FW = 8, AW = 4, IW = 20, BW = 3, BC = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [BC*IW-1:0] last_frame = '0;
  logic cmd_valid = 1'b0, far_wr = 1'b0, beat_valid = 1'b0;
  logic [4:0] cmd_code = '0;
  logic [31:0] far_wdata = '0;
  logic [127:0] beat_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [FW*32-1:0] rd_frame;
  logic [31:0] far_q;
  logic row_cfgd, row_on, wcfg, rcfg, overflow, commit;
  logic [IW+BW-1:0] commit_addr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cfg_frame_writer #(.FRAME_WORDS(FW), .MEM_AW(AW), .IDX_W(IW), .BT_W(BW), .BT_COUNT(BC)) i_cfg_frame_writer (
    .clk(clk), .rst_n(rst_n), .last_frame(last_frame), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .far_wr(far_wr), .far_wdata(far_wdata), .beat_valid(beat_valid), .beat_data(beat_data),
    .rd_addr(rd_addr), .rd_frame(rd_frame), .far_q(far_q), .row_cfgd(row_cfgd), .row_on(row_on),
    .wcfg(wcfg), .rcfg(rcfg), .overflow(overflow), .commit(commit), .commit_addr(commit_addr));

  // {code, expected {row_on, wcfg, rcfg}}
  localparam logic [7:0] CMD_TAB [10] = '{
    {5'd2, 3'b100}, {5'd1, 3'b110}, {5'd4, 3'b111}, {5'd0, 3'b111}, {5'd6, 3'b111},
    {5'd31, 3'b111}, {5'd5, 3'b100}, {5'd3, 3'b000}, {5'd1, 3'b010}, {5'd5, 3'b000}};

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input int s);
    return {32'(s + 3), 32'(s + 2), 32'(s + 1), 32'(s)};
  endfunction

  task automatic cmd(input logic [4:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk); far_wr = 1'b1; far_wdata = v;
    @(negedge clk); far_wr = 1'b0;
  endtask

  task automatic beats(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); beat_valid = 1'b1; beat_data = mk(seed + 4*i);
    end
    @(negedge clk); beat_valid = 1'b0;
  endtask

  task automatic idle_no_commit(input string req);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk(req, commit, 1'b0);
    end
  endtask

  task automatic send_frame(input int seed, input logic [22:0] exp_ca, input logic [31:0] exp_far);
    beats(2, seed);
    @(negedge clk);
    chk("R10 commit pulse", commit, 1'b1);
    chk("R10 commit_addr", commit_addr, exp_ca);
    chk("R6 address step", far_q, exp_far);
    rd_addr = exp_ca[AW-1:0];
    #1 chk("R5 frame content", rd_frame, {mk(seed + 4), mk(seed)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd_addr = 4'd3;
    #1;
    chk("R1 flags", {row_on, wcfg, rcfg}, 3'b000);
    chk("R1 far", far_q, 32'd0);
    chk("R1 overflow/commit", {overflow, commit}, 2'b00);
    chk("R1 memory", rd_frame, '0);
    rst_n = 1'b1;

    chk("R2 unconfigured", row_cfgd, 1'b0);
    cmd(5'd2); chk("R2 command ignored", row_on, 1'b0);
    cmd(5'd1); chk("R2 command ignored", wcfg, 1'b0);
    load(32'h5); chk("R2 load ignored", far_q, 32'd0);

    last_frame[0*IW +: IW] = 20'd2;
    last_frame[1*IW +: IW] = 20'd0;
    for (int b = 2; b < BC; b++) last_frame[b*IW +: IW] = 20'd1;
    @(negedge clk);
    chk("R2 configured", row_cfgd, 1'b1);

    foreach (CMD_TAB[i]) begin
      cmd(CMD_TAB[i][7:3]);
      chk("R3 command table", {row_on, wcfg, rcfg}, CMD_TAB[i][2:0]);
    end

    cmd(5'd1);
    beats(1, 32'h100);
    idle_no_commit("R4 row off drops beat");
    cmd(5'd5); cmd(5'd2); cmd(5'd4);
    beats(1, 32'h200);
    idle_no_commit("R4 read mode drops beat");
    cmd(5'd1);
    beats(1, 32'h300);
    idle_no_commit("R4 half frame waits");
    beats(1, 32'h304);
    @(negedge clk);
    chk("R10 commit pulse", commit, 1'b1);
    chk("R6 index plus one", far_q, 32'h1);
    rd_addr = 4'd0;
    #1 chk("R5 frame words order", rd_frame, {mk(32'h304), mk(32'h300)});
    @(negedge clk); chk("R10 single pulse", commit, 1'b0);

    send_frame(32'h400, 23'h1, 32'h2);
    send_frame(32'h500, 23'h2, 32'h0010_0000);
    send_frame(32'h600, 23'h10_0000, 32'h0020_0000);

    load(32'hFFE0_0001);
    chk("R8 reserved bits zero", far_q, 32'h01E0_0001);
    send_frame(32'h700, 23'h60_0001, 32'h01E0_0000);
    chk("R7 type stays 6", far_q[22:20], 3'd6);

    beats(3, 32'h800);
    chk("R9 overflow set", overflow, 1'b1);
    chk("R10 commit on overflow", commit, 1'b1);
    rd_addr = 4'd0;
    #1 chk("R9 frame without dropped beat", rd_frame, {mk(32'h804), mk(32'h800)});
    beats(1, 32'h900);
    idle_no_commit("R9 dropped beat not kept");
    beats(1, 32'h904);
    @(negedge clk);
    chk("R10 commit after drop", commit, 1'b1);
    rd_addr = 4'd1;
    #1 chk("R9 next frame", rd_frame, {mk(32'h904), mk(32'h900)});
    chk("R9 overflow sticky", overflow, 1'b1);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset overflow", overflow, 1'b0);
    chk("R1 reset far", far_q, 32'd0);
    chk("R1 reset flags", {row_on, wcfg, rcfg}, 3'b000);
    chk("R1 reset memory", rd_frame, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule